// File: doc/BRIEF.md
# Keyed-access watchdog timer

This block is a watchdog counter that sits behind a small 32-bit register bus. Its configuration cannot be changed by ordinary writes. Software first writes a 32-bit unlock key to the counter slot. That opens a short configuration window in which the timeout, the window floor and the control word can be written. Software feeds the watchdog by writing a second 32-bit key to the same slot, which returns the count to zero. Any other word written to that slot is treated as a runaway program and raises the reset request at once.

The counter advances on every bus clock or on an external counting enable, whichever is selected. When the count reaches the timeout, one of two things happens. If the interrupt is enabled, an interrupt flag is raised and a grace period of a fixed number of counting ticks follows before reset is requested. Otherwise reset is requested on the next clock. A control write with the update bit cleared freezes the configuration until the next reset.

The register bus is a plain control path with no back-pressure. A write is taken in the single cycle that `bus_wr` is high and never stalls. Read data is combinational from `bus_addr`.

Top module: `keywd_top`

## Requirements
- R1: The register slots are selected by the word index on `bus_addr`: 0 is control, 1 is counter/key, 2 is timeout and 3 is window floor. The control bits are: 0 enable; 1 clock select (1 = count on `tick_en`, 0 = count every clock); 2 interrupt enable; 3 window enable; 4 update allowed; 5 unlocked (read-only); 6 configuration done (read-only); 7 interrupt flag (writing 1 clears it). Slot 1 reads the counter, and slots 2 and 3 read their values zero-extended.
- R2: After reset, control reads 0x13, the timeout reads DEF_TIMEOUT, the counter and window floor read 0, and `irq_o` and `wdog_rst_o` are low.
- R3: Writing 0xD928C520 with all four byte enables to slot 1 while update allowed is 1 sets unlocked and clears configuration done on the next cycle. While update allowed is 0, the same write changes nothing.
- R4: Writes to slots 2 and 3, and to control bits 0 to 4, take effect only while unlocked and only with all four byte enables. Otherwise they are ignored.
- R5: Unlocked stays high for exactly UNLOCK_CYCLES clocks after the unlock write, unless an accepted control write clears it earlier.
- R6: An accepted control write sets configuration done, clears unlocked and clears the counter. If it writes update allowed = 0, no later unlock succeeds until reset.
- R7: Writing 0xB480A602 with all four byte enables to slot 1 clears the counter on the next cycle.
- R8: Any other word, or any write with fewer than four byte enables, to slot 1 raises `wdog_rst_o` on the next cycle.
- R9: With window enable set, a feed write while the counter is below the window floor raises `wdog_rst_o` on the next cycle.
- R10: While enabled, the counter adds one per selected tick and stops at the timeout. While disabled, it reads 0.
- R11: When the counter equals the timeout and interrupt enable is 0, `wdog_rst_o` rises on the next cycle.
- R12: When the counter equals the timeout and interrupt enable is 1, `irq_o` rises on the next cycle and `wdog_rst_o` follows GRACE_TICKS selected ticks later. A feed during the grace period cancels the pending reset. Writing 1 to bit 7 clears `irq_o`.
- R13: Once `wdog_rst_o` is high, it stays high until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Register word index |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_en | input | 1 | Counting clock enable, used when clock select is 1 |
| irq_o | output | 1 | Timeout interrupt flag |
| wdog_rst_o | output | 1 | Sticky reset request |

## Verification
The key slot is tried with both exact keys, with single-bit and half-swapped neighbours of the keys, with all-zero and all-one words, and with partial byte enables on the true keys. Together these separate a correct full-word match from a loose or byte-wise one. The timeout path is run with the interrupt off and on, with a feed inside the grace period, and with feeds just at and below the window floor. This distinguishes an off-by-one in the expiry, grace or window compare. Locking is exercised by writing configuration while locked, after the window has aged out, after a freezing control write and after a second unlock, to show that each gate works on its own.

// File: rtl/keywd_pkg.sv
package keywd_pkg;

  localparam logic [31:0] KEY_OPEN = 32'hD928C520;
  localparam logic [31:0] KEY_FEED = 32'hB480A602;

  typedef enum logic [1:0] {
    IDX_CTRL = 2'd0,
    IDX_CNT  = 2'd1,
    IDX_TOUT = 2'd2,
    IDX_WIN  = 2'd3
  } reg_idx_e;

  localparam int B_UNLK = 5;
  localparam int B_DONE = 6;
  localparam int B_IRQF = 7;

  // packed so that en lands on bit 0 and upd on bit 4
  typedef struct packed {
    logic upd;
    logic win_en;
    logic irq_en;
    logic clk_sel;
    logic en;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{upd: 1'b1, win_en: 1'b0, irq_en: 1'b0,
                                 clk_sel: 1'b1, en: 1'b1};

endpackage

// File: rtl/keywd_keychk.sv
module keywd_keychk
  import keywd_pkg::*;
(
  input  logic        wr,
  input  logic [1:0]  addr,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic        hit_open,
  output logic        hit_feed,
  output logic        hit_bad
);

  localparam int NKEYS = 2;
  localparam logic [31:0] KEYS [NKEYS] = '{KEY_OPEN, KEY_FEED};

  logic [NKEYS-1:0] match;
  logic             key_slot;
  logic             full;

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    assign match[k] = (wdata == KEYS[k]);
  end

  assign key_slot = wr && (addr == IDX_CNT);
  assign full     = &be;
  assign hit_open = key_slot && full && match[0];
  assign hit_feed = key_slot && full && match[1];
  assign hit_bad  = key_slot && !(full && (|match));

endmodule

// File: rtl/keywd_cfg.sv
module keywd_cfg
  import keywd_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DEF_TIMEOUT   = 1024,
  parameter int UNLOCK_CYCLES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic             full_be,
  input  logic [CNT_W-1:0] wdata,
  input  logic             hit_open,
  output cfg_t             cfg_q,
  output logic [CNT_W-1:0] tout_q,
  output logic [CNT_W-1:0] win_q,
  output logic             unlocked,
  output logic             cfg_done,
  output logic             cfg_apply,
  output logic             irq_clr
);

  localparam int WIN_W = (UNLOCK_CYCLES > 1) ? $clog2(UNLOCK_CYCLES) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(UNLOCK_CYCLES - 1);

  logic             wr_ok;
  logic             open_ok;
  logic [WIN_W-1:0] wcnt_q;

  assign wr_ok     = wr && full_be;
  assign cfg_apply = wr_ok && unlocked && (addr == IDX_CTRL);
  assign irq_clr   = wr_ok && (addr == IDX_CTRL) && wdata[B_IRQF];
  // once a control write cleared upd, no unlock is honoured again
  assign open_ok   = hit_open && cfg_q.upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      wcnt_q   <= '0;
    end else if (open_ok) begin
      unlocked <= 1'b1;
      wcnt_q   <= '0;
    end else if (cfg_apply) begin
      unlocked <= 1'b0;
      wcnt_q   <= '0;
    end else if (unlocked) begin
      if (wcnt_q == WIN_LAST) begin
        unlocked <= 1'b0;
        wcnt_q   <= '0;
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_done <= 1'b0;
    else if (open_ok)   cfg_done <= 1'b0;
    else if (cfg_apply) cfg_done <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= CFG_RESET;
    else if (cfg_apply) cfg_q <= cfg_t'(wdata[4:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_q <= CNT_W'(DEF_TIMEOUT);
      win_q  <= '0;
    end else if (wr_ok && unlocked) begin
      if (addr == IDX_TOUT) tout_q <= wdata;
      if (addr == IDX_WIN)  win_q  <= wdata;
    end
  end

endmodule

// File: rtl/keywd_core.sv
module keywd_core #(
  parameter int CNT_W       = 16,
  parameter int GRACE_TICKS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clk_sel,
  input  logic             irq_en,
  input  logic             win_en,
  input  logic [CNT_W-1:0] tout,
  input  logic [CNT_W-1:0] win_floor,
  input  logic             tick_en,
  input  logic             hit_feed,
  input  logic             hit_bad,
  input  logic             cfg_apply,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_flag,
  output logic             rst_req
);

  localparam int GW = $clog2(GRACE_TICKS + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GRACE_TICKS - 1);

  logic          tick;
  logic          feed_early;
  logic          feed_ok;
  logic          expired;
  logic          irq_set;
  logic          armed_q;
  logic [GW-1:0] gcnt_q;

  assign tick       = clk_sel ? tick_en : 1'b1;
  assign feed_early = hit_feed && win_en && (cnt_q < win_floor);
  assign feed_ok    = hit_feed && !feed_early;
  assign expired    = en && (cnt_q >= tout);
  assign irq_set    = expired && irq_en && !armed_q && !feed_ok && !cfg_apply;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                cnt_q <= '0;
    else if (!en || feed_ok || cfg_apply)      cnt_q <= '0;
    else if (tick && (cnt_q < tout))           cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gcnt_q  <= '0;
    end else if (feed_ok || cfg_apply) begin
      armed_q <= 1'b0;
      gcnt_q  <= '0;
    end else if (irq_set) begin
      armed_q <= 1'b1;
      gcnt_q  <= '0;
    end else if (armed_q && tick && (gcnt_q != G_LAST)) begin
      gcnt_q <= gcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq_flag <= 1'b0;
    else if (irq_set) irq_flag <= 1'b1;
    else if (irq_clr) irq_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   rst_req <= 1'b0;
    else if (hit_bad || feed_early)               rst_req <= 1'b1;
    else if (expired && !irq_en)                  rst_req <= 1'b1;
    else if (armed_q && tick && gcnt_q == G_LAST) rst_req <= 1'b1;
  end

endmodule

// File: rtl/keywd_top.sv
module keywd_top
  import keywd_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int DEF_TIMEOUT   = 1024,
  parameter int UNLOCK_CYCLES = 128,
  parameter int GRACE_TICKS   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [3:0]  bus_be,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_en,
  output logic        irq_o,
  output logic        wdog_rst_o
);

  localparam int PAD_W = 32 - CNT_W;

  logic             hit_open;
  logic             hit_feed;
  logic             hit_bad;
  cfg_t             cfg_q;
  logic [CNT_W-1:0] tout_q;
  logic [CNT_W-1:0] win_q;
  logic [CNT_W-1:0] cnt_q;
  logic             unlocked;
  logic             cfg_done;
  logic             cfg_apply;
  logic             irq_clr;
  logic             irq_flag;

  keywd_keychk u_keys (
    .wr       (bus_wr),
    .addr     (bus_addr),
    .be       (bus_be),
    .wdata    (bus_wdata),
    .hit_open (hit_open),
    .hit_feed (hit_feed),
    .hit_bad  (hit_bad)
  );

  keywd_cfg #(
    .CNT_W         (CNT_W),
    .DEF_TIMEOUT   (DEF_TIMEOUT),
    .UNLOCK_CYCLES (UNLOCK_CYCLES)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .full_be   (&bus_be),
    .wdata     (bus_wdata[CNT_W-1:0]),
    .hit_open  (hit_open),
    .cfg_q     (cfg_q),
    .tout_q    (tout_q),
    .win_q     (win_q),
    .unlocked  (unlocked),
    .cfg_done  (cfg_done),
    .cfg_apply (cfg_apply),
    .irq_clr   (irq_clr)
  );

  keywd_core #(
    .CNT_W       (CNT_W),
    .GRACE_TICKS (GRACE_TICKS)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (cfg_q.en),
    .clk_sel   (cfg_q.clk_sel),
    .irq_en    (cfg_q.irq_en),
    .win_en    (cfg_q.win_en),
    .tout      (tout_q),
    .win_floor (win_q),
    .tick_en   (tick_en),
    .hit_feed  (hit_feed),
    .hit_bad   (hit_bad),
    .cfg_apply (cfg_apply),
    .irq_clr   (irq_clr),
    .cnt_q     (cnt_q),
    .irq_flag  (irq_flag),
    .rst_req   (wdog_rst_o)
  );

  assign irq_o = irq_flag;

  always_comb begin
    unique case (bus_addr)
      IDX_CTRL: bus_rdata = {24'd0, irq_flag, cfg_done, unlocked, cfg_q};
      IDX_CNT:  bus_rdata = {{PAD_W{1'b0}}, cnt_q};
      IDX_TOUT: bus_rdata = {{PAD_W{1'b0}}, tout_q};
      default:  bus_rdata = {{PAD_W{1'b0}}, win_q};
    endcase
  end

endmodule

// File: rtl/keywd_chk.sv
module keywd_chk
  import keywd_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int UNLOCK_CYCLES = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [3:0]       bus_be,
  input logic [31:0]      bus_wdata,
  input logic             unlocked,
  input logic             cfg_upd,
  input logic             cfg_en,
  input logic             cfg_irq,
  input logic             cfg_win,
  input logic [CNT_W-1:0] tout_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wdog_rst_o
);

  localparam int RW = $clog2(UNLOCK_CYCLES + 2) + 1;

  logic          key_wr;
  logic          open_wr;
  logic          feed_wr;
  logic [RW-1:0] run_q;

  assign key_wr  = bus_wr && (bus_addr == IDX_CNT);
  assign open_wr = key_wr && (bus_be == 4'hF) && (bus_wdata == KEY_OPEN);
  assign feed_wr = key_wr && (bus_be == 4'hF) && (bus_wdata == KEY_FEED);

  // length of the current unlocked run, restarted by each unlock key
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (open_wr && cfg_upd) run_q <= RW'(1);
    else if (unlocked)           run_q <= run_q + 1'b1;
    else                         run_q <= '0;
  end

  p_bad_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !open_wr && !feed_wr) |=> wdog_rst_o);

  p_locked_tout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == IDX_TOUT && !unlocked) |=> $stable(tout_q));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_upd && !unlocked) |=> !unlocked);

  p_rst_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_o |=> wdog_rst_o);

  p_feed_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_wr && !cfg_win) |=> (cnt_q == '0));

  p_open_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |-> (run_q <= RW'(UNLOCK_CYCLES)));

  p_expire_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && !cfg_irq && cnt_q >= tout_q) |=> wdog_rst_o);

endmodule

bind keywd_top keywd_chk #(
  .CNT_W         (CNT_W),
  .UNLOCK_CYCLES (UNLOCK_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata),
  .unlocked   (unlocked),
  .cfg_upd    (cfg_q.upd),
  .cfg_en     (cfg_q.en),
  .cfg_irq    (cfg_q.irq_en),
  .cfg_win    (cfg_q.win_en),
  .tout_q     (tout_q),
  .cnt_q      (cnt_q),
  .wdog_rst_o (wdog_rst_o)
);

// File: tb/sim_keywd_top.sv
module sim_keywd_top;

  localparam int UNLOCK = 128;
  localparam int GRACE  = 8;
  localparam logic [31:0] OPEN = 32'hD928C520;
  localparam logic [31:0] FEED = 32'hB480A602;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [3:0]  bus_be = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_en = 1'b0;
  logic        irq_o;
  logic        wdog_rst_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  keywd_top #(
    .CNT_W(16), .DEF_TIMEOUT(1024), .UNLOCK_CYCLES(UNLOCK), .GRACE_TICKS(GRACE)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq_o(irq_o), .wdog_rst_o(wdog_rst_o)
  );

  // key-slot vectors: word, byte enables, expected unlocked, expected reset
  localparam int NV = 9;
  localparam logic [31:0] V_WORD [NV] = '{OPEN, FEED, 32'h0, 32'hD928C521,
    32'hB480A603, 32'hC520D928, 32'hFFFFFFFF, OPEN, FEED};
  localparam logic [3:0] V_BE [NV] = '{4'hF, 4'hF, 4'hF, 4'hF, 4'hF, 4'hF,
    4'hF, 4'h7, 4'hE};
  localparam logic V_UNLK [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0};
  localparam logic V_RST [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b1};

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    tick_en = 1'b0;
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d,
                    input logic [3:0] be);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_be = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic configure(input logic [31:0] tout, input logic [31:0] ctrl);
    wr(2'd1, OPEN, 4'hF);
    wr(2'd2, tout, 4'hF);
    wr(2'd0, ctrl, 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] d;

    // table walk over the key slot
    for (int i = 0; i < NV; i++) begin
      do_reset();
      wr(2'd1, V_WORD[i], V_BE[i]);
      rd(2'd0, d);
      check($sformatf("R3 unlock vec%0d", i), {31'd0, d[5]}, {31'd0, V_UNLK[i]});
      check($sformatf("R8 reset vec%0d", i), {31'd0, wdog_rst_o}, {31'd0, V_RST[i]});
    end

    // R2 reset state
    do_reset();
    rd(2'd0, d); check("R2 ctrl", d, 32'h13);
    rd(2'd2, d); check("R2 tout", d, 32'd1024);
    rd(2'd1, d); check("R2 cnt", d, 32'd0);
    rd(2'd3, d); check("R2 win", d, 32'd0);
    check("R2 outputs", {30'd0, irq_o, wdog_rst_o}, 32'd0);

    // R4 writes while locked are ignored
    @(negedge clk);
    wr(2'd2, 32'd5, 4'hF);
    wr(2'd3, 32'd7, 4'hF);
    rd(2'd2, d); check("R4 locked tout", d, 32'd1024);
    rd(2'd3, d); check("R4 locked win", d, 32'd0);

    // R1 R4 R6 R10 R11: basic timeout, irq off, every-clock counting
    do_reset();
    wr(2'd1, OPEN, 4'hF);
    rd(2'd0, d); check("R3 unlocked flag", d & 32'h60, 32'h20);
    @(negedge clk);
    wr(2'd2, 32'd20, 4'h3);
    rd(2'd2, d); check("R4 partial be", d, 32'd1024);
    @(negedge clk);
    wr(2'd2, 32'd20, 4'hF);
    wr(2'd0, 32'h11, 4'hF);
    rd(2'd0, d); check("R6 ctrl after apply", d, 32'h51);
    rd(2'd2, d); check("R1 tout readback", d, 32'd20);
    rd(2'd1, d); check("R6 cnt cleared", d, 32'd0);
    repeat (20) @(negedge clk);
    rd(2'd1, d); check("R10 cnt at tout", d, 32'd20);
    check("R11 no reset yet", {31'd0, wdog_rst_o}, 32'd0);
    @(negedge clk);
    check("R11 reset asserted", {31'd0, wdog_rst_o}, 32'd1);
    rd(2'd1, d); check("R10 cnt stops", d, 32'd20);

    // R12 interrupt then grace
    do_reset();
    configure(32'd10, 32'h15);
    repeat (10) @(negedge clk);
    check("R12 irq not yet", {31'd0, irq_o}, 32'd0);
    @(negedge clk);
    check("R12 irq raised", {30'd0, irq_o, wdog_rst_o}, 32'd2);
    repeat (GRACE - 1) @(negedge clk);
    check("R12 grace holds", {31'd0, wdog_rst_o}, 32'd0);
    @(negedge clk);
    check("R12 reset after grace", {31'd0, wdog_rst_o}, 32'd1);
    wr(2'd1, FEED, 4'hF);
    wr(2'd0, 32'h80, 4'hF);
    check("R12 irq cleared", {31'd0, irq_o}, 32'd0);
    check("R13 reset sticky", {31'd0, wdog_rst_o}, 32'd1);

    // R7 R12 feed during grace cancels
    do_reset();
    configure(32'd10, 32'h15);
    repeat (14) @(negedge clk);
    check("R12 irq before feed", {31'd0, irq_o}, 32'd1);
    wr(2'd1, FEED, 4'hF);
    rd(2'd1, d); check("R7 feed clears", d, 32'd0);
    repeat (8) @(negedge clk);
    rd(2'd1, d); check("R7 counts again", d, 32'd8);
    check("R12 feed cancels reset", {31'd0, wdog_rst_o}, 32'd0);

    // R9 window floor
    do_reset();
    wr(2'd1, OPEN, 4'hF);
    wr(2'd3, 32'd8, 4'hF);
    wr(2'd2, 32'd30, 4'hF);
    wr(2'd0, 32'h19, 4'hF);
    repeat (8) @(negedge clk);
    wr(2'd1, FEED, 4'hF);
    check("R9 feed at floor ok", {31'd0, wdog_rst_o}, 32'd0);
    rd(2'd1, d); check("R9 feed cleared", d, 32'd0);
    @(negedge clk);
    repeat (2) @(negedge clk);
    wr(2'd1, FEED, 4'hF);
    check("R9 early feed resets", {31'd0, wdog_rst_o}, 32'd1);

    // R6 R3 freeze with update=0
    do_reset();
    configure(32'd50, 32'h00);
    rd(2'd0, d); check("R6 frozen ctrl", d, 32'h40);
    @(negedge clk);
    wr(2'd1, OPEN, 4'hF);
    rd(2'd0, d); check("R3 unlock refused", d & 32'h20, 32'h0);
    check("R3 refused key no reset", {31'd0, wdog_rst_o}, 32'd0);
    @(negedge clk);
    wr(2'd2, 32'd9, 4'hF);
    rd(2'd2, d); check("R6 tout frozen", d, 32'd50);
    repeat (60) @(negedge clk);
    rd(2'd1, d); check("R10 disabled cnt", d, 32'd0);
    check("R10 disabled no reset", {31'd0, wdog_rst_o}, 32'd0);

    // R3 second unlock with update=1
    do_reset();
    configure(32'd40, 32'h10);
    wr(2'd1, OPEN, 4'hF);
    rd(2'd0, d); check("R3 reunlock", d, 32'h30);
    @(negedge clk);
    wr(2'd2, 32'd41, 4'hF);
    wr(2'd0, 32'h10, 4'hF);
    rd(2'd2, d); check("R3 reconfig tout", d, 32'd41);
    rd(2'd0, d); check("R6 done again", d, 32'h50);

    // R5 window ages out
    do_reset();
    wr(2'd1, OPEN, 4'hF);
    repeat (UNLOCK - 1) @(negedge clk);
    rd(2'd0, d); check("R5 still open", d & 32'h20, 32'h20);
    @(negedge clk);
    rd(2'd0, d); check("R5 closed", d & 32'h20, 32'h0);
    @(negedge clk);
    wr(2'd2, 32'd3, 4'hF);
    rd(2'd2, d); check("R5 late write ignored", d, 32'd1024);

    // R10 external tick select
    do_reset();
    configure(32'd100, 32'h13);
    repeat (5) @(negedge clk);
    rd(2'd1, d); check("R10 no tick", d, 32'd0);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    tick_en = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, d); check("R10 tick count", d, 32'd4);

    report();
  end

endmodule